// File: doc/BRIEF.md
# Bidirectional I/O Port with Pin-Change and Edge Interrupts

This block is an eight-bit general-purpose I/O port as seen from a small controller's register bus. Every bit owns an output value latch and a direction latch. From these the block drives, per bit, a pad output, a pad output enable and a weak pull-up enable. The pad inputs pass through a two-flop synchronizer, and a read of the port register returns those synchronized levels.

The upper half of the port watches for pin changes. Each read of the port register copies the synchronized upper-nibble levels into a compare latch. Any input bit of that nibble that then differs from its copy sets a sticky change flag. Bit 0 also serves as an external interrupt input, and a bit in the option register selects its active edge. Each flag stays set until its clear strobe is pulsed, and software is expected to read the port before it clears the change flag.

Top module: `gpio_chg_port`

## Requirements
- R1: A write to the port register loads the output latch, and `pad_out` shows it from the next cycle. A write to the direction register sets `pad_oe` to the inverse of the written value from the next cycle (direction 1 = input, driver off).
- R2: The direction register (0x086) and the option register (0x081) read back their contents. Both hold 0xFF after reset.
- R3: A read of the port register (0x006) returns the pad levels after a two-flop synchronizer, not the output latch. A pad change shows in the read data only from the second rising edge after it.
- R4: `pad_pu[i]` is 1 exactly when direction bit i is 1 and option bit 7 is 0.
- R5: The change flag sets when any bit 7..4 that is an input differs from the value captured at the last port read. Output bits in that nibble are ignored.
- R6: The change flag stays set until `chg_clr` is pulsed. A clear while a mismatch persists leaves the flag set.
- R7: Changes on bits 3..0 never set the change flag.
- R8: The external flag sets on an edge of synchronized bit 0: rising when option bit 6 is 1, falling when it is 0. The other edge has no effect.
- R9: The external flag stays set until `ext_clr` is pulsed.
- R10: Each register also answers at its address plus 0x100. Writes to any other address change nothing. `bus_rdata` is 0 when `bus_rd` is low or the address is unmapped.
- R11: Reset does not change the output latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 9 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, same cycle as `bus_rd` |
| pad_in | input | 8 | Pad input levels |
| pad_out | output | 8 | Pad output values |
| pad_oe | output | 8 | Pad output enables |
| pad_pu | output | 8 | Weak pull-up enables |
| chg_clr | input | 1 | Clears the change flag |
| chg_flag | output | 1 | Sticky upper-nibble change flag |
| ext_clr | input | 1 | Clears the external flag |
| ext_flag | output | 1 | Sticky bit 0 edge flag |

## Verification
The assertions check the following on every cycle: a register write reaches the pads one cycle later, pull-ups never coexist with an enabled driver, both flags hold until cleared, idle reads return zero, and a change flag rises only while some upper bit is an input. Only the bench scenarios can show the rest. These are the exact synchronizer latency seen through port reads, that comparison is made against the last-read snapshot rather than the previous cycle, and that a clear loses to a persisting mismatch. They also cover edge polarity selection, mirror and unmapped decode, and an output latch that survives reset.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
   localparam int PU_N_BIT  = 7;   // option bit: pull-ups disabled when 1
   localparam int EDGE_BIT  = 6;   // option bit: 1 rising, 0 falling
   localparam logic [8:0] REG_PORT = 9'h006;
   localparam logic [8:0] REG_DIR  = 9'h086;
   localparam logic [8:0] REG_OPT  = 9'h081;
   localparam logic [8:0] MIRROR   = 9'h100;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int W      = 8,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [W-1:0] stg [STAGES];
         always_ff @(posedge clk) begin
            if (!rst_n) stg[0] <= '0;
            else        stg[0] <= d;
         end
         for (genvar k = 1; k < STAGES; k++) begin : g_stage
            always_ff @(posedge clk) begin
               if (!rst_n) stg[k] <= '0;
               else        stg[k] <= stg[k-1];
            end
         end
         assign q = stg[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs #(
   parameter int W  = 8,
   parameter int AW = 9,
   parameter logic [AW-1:0] A_PORT = 9'h006,
   parameter logic [AW-1:0] A_DIR  = 9'h086,
   parameter logic [AW-1:0] A_OPT  = 9'h081,
   parameter logic [AW-1:0] A_MIR  = 9'h100
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] addr,
   input  logic          wr,
   input  logic          rd,
   input  logic [W-1:0]  wdata,
   input  logic [W-1:0]  pins_s,
   output logic [W-1:0]  rdata,
   output logic [W-1:0]  dat_q,
   output logic [W-1:0]  dir_q,
   output logic [W-1:0]  opt_q,
   output logic          port_rd
);
   logic hit_port, hit_dir, hit_opt;

   assign hit_port = (addr == A_PORT) || (addr == (A_PORT | A_MIR));
   assign hit_dir  = (addr == A_DIR)  || (addr == (A_DIR  | A_MIR));
   assign hit_opt  = (addr == A_OPT)  || (addr == (A_OPT  | A_MIR));

   // output latch keeps its value across reset
   always_ff @(posedge clk) begin
      if (wr && hit_port) dat_q <= wdata;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dir_q <= '1;
         opt_q <= '1;
      end else if (wr) begin
         if (hit_dir) dir_q <= wdata;
         if (hit_opt) opt_q <= wdata;
      end
   end

   always_comb begin
      rdata = '0;
      if (rd) begin
         if (hit_port)     rdata = pins_s;
         else if (hit_dir) rdata = dir_q;
         else if (hit_opt) rdata = opt_q;
      end
   end

   assign port_rd = rd && hit_port;
endmodule

// File: rtl/gpio_chg.sv
module gpio_chg #(
   parameter int NB = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [NB-1:0] pins_hi,
   input  logic [NB-1:0] dir_hi,
   input  logic          capture,
   input  logic          clr,
   output logic          flag
);
   logic [NB-1:0] snap;
   logic          mism;

   assign mism = |((pins_hi ^ snap) & dir_hi);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         snap <= '0;
         flag <= 1'b0;
      end else begin
         if (capture) snap <= pins_hi;
         flag <= mism | (flag & ~clr);
      end
   end
endmodule

// File: rtl/gpio_edge.sv
module gpio_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   input  logic rise_sel,
   input  logic clr,
   output logic flag
);
   logic prev, hit;

   assign hit = rise_sel ? (pin & ~prev) : (~pin & prev);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev <= 1'b0;
         flag <= 1'b0;
      end else begin
         prev <= pin;
         flag <= hit | (flag & ~clr);
      end
   end
endmodule

// File: rtl/gpio_chg_port.sv
module gpio_chg_port
   import gpio_pkg::*;
#(
   parameter int PORT_W = 8,
   parameter int ADDR_W = 9,
   parameter int CHG_LO = 4,
   parameter int SYNC_N = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [PORT_W-1:0] bus_wdata,
   output logic [PORT_W-1:0] bus_rdata,
   input  logic [PORT_W-1:0] pad_in,
   output logic [PORT_W-1:0] pad_out,
   output logic [PORT_W-1:0] pad_oe,
   output logic [PORT_W-1:0] pad_pu,
   input  logic              chg_clr,
   output logic              chg_flag,
   input  logic              ext_clr,
   output logic              ext_flag
);
   localparam int NB = PORT_W - CHG_LO;

   generate
      if (CHG_LO < 1 || CHG_LO >= PORT_W) begin : g_bad_lo
         $error("CHG_LO must lie inside the port");
      end
      if (PORT_W <= PU_N_BIT) begin : g_bad_w
         $error("PORT_W too narrow for option bits");
      end
      if (ADDR_W != 9) begin : g_bad_aw
         $error("ADDR_W must be 9 for the register map");
      end
   endgenerate

   logic [PORT_W-1:0] pins_s, dat_q, dir_q, opt_q;
   logic              port_rd;

   gpio_sync #(.W(PORT_W), .STAGES(SYNC_N)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pad_in), .q(pins_s)
   );

   gpio_regs #(
      .W(PORT_W), .AW(ADDR_W),
      .A_PORT(REG_PORT), .A_DIR(REG_DIR), .A_OPT(REG_OPT), .A_MIR(MIRROR)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wr(bus_wr), .rd(bus_rd),
      .wdata(bus_wdata), .pins_s(pins_s), .rdata(bus_rdata),
      .dat_q(dat_q), .dir_q(dir_q), .opt_q(opt_q), .port_rd(port_rd)
   );

   gpio_chg #(.NB(NB)) u_chg (
      .clk(clk), .rst_n(rst_n),
      .pins_hi(pins_s[PORT_W-1:CHG_LO]), .dir_hi(dir_q[PORT_W-1:CHG_LO]),
      .capture(port_rd), .clr(chg_clr), .flag(chg_flag)
   );

   gpio_edge u_edge (
      .clk(clk), .rst_n(rst_n), .pin(pins_s[0]), .rise_sel(opt_q[EDGE_BIT]),
      .clr(ext_clr), .flag(ext_flag)
   );

   assign pad_out = dat_q;
   assign pad_oe  = ~dir_q;

   generate
      for (genvar i = 0; i < PORT_W; i++) begin : g_pu
         assign pad_pu[i] = dir_q[i] & ~opt_q[PU_N_BIT];
      end
   endgenerate
endmodule

// File: rtl/gpio_chk.sv
module gpio_chk #(
   parameter int PORT_W = 8,
   parameter int ADDR_W = 9,
   parameter int CHG_LO = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_wr,
   input logic              bus_rd,
   input logic [PORT_W-1:0] bus_wdata,
   input logic [PORT_W-1:0] bus_rdata,
   input logic [PORT_W-1:0] pad_out,
   input logic [PORT_W-1:0] pad_oe,
   input logic [PORT_W-1:0] pad_pu,
   input logic              chg_clr,
   input logic              chg_flag,
   input logic              ext_clr,
   input logic              ext_flag
);
   logic wr_port, wr_dir;
   assign wr_port = bus_wr && (bus_addr[ADDR_W-2:0] == 8'h06);
   assign wr_dir  = bus_wr && (bus_addr[ADDR_W-2:0] == 8'h86);

   AST_WR_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      wr_port |=> pad_out == $past(bus_wdata));                          // R1
   AST_WR_DIR: assert property (@(posedge clk) disable iff (!rst_n)
      wr_dir |=> pad_oe == ~$past(bus_wdata));                           // R1
   AST_PU_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      (pad_pu & pad_oe) == '0);                                          // R4
   AST_CHG_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(chg_flag) |-> $past(~pad_oe[PORT_W-1:CHG_LO]) != '0);        // R5
   AST_CHG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      chg_flag && !chg_clr |=> chg_flag);                                // R6
   AST_EXT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      ext_flag && !ext_clr |=> ext_flag);                                // R9
   AST_RD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |-> bus_rdata == '0);                                      // R10
endmodule

bind gpio_chg_port gpio_chk #(.PORT_W(PORT_W), .ADDR_W(ADDR_W), .CHG_LO(CHG_LO)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
   .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_out(pad_out), .pad_oe(pad_oe),
   .pad_pu(pad_pu), .chg_clr(chg_clr), .chg_flag(chg_flag), .ext_clr(ext_clr),
   .ext_flag(ext_flag)
);

// File: tb/test_gpio_chg_port.sv
module test_gpio_chg_port;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [8:0] bus_addr = '0;
   logic       bus_wr = 1'b0, bus_rd = 1'b0;
   logic [7:0] bus_wdata = '0, pad_in = '0;
   logic       chg_clr = 1'b0, ext_clr = 1'b0;
   logic [7:0] bus_rdata, pad_out, pad_oe, pad_pu;
   logic       chg_flag, ext_flag;

   int checks = 0, errors = 0;
   bit done = 0;

   always #2.5 clk = ~clk;   // 200 MHz

   gpio_chg_port i_gpio_chg_port (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in), .pad_out(pad_out),
      .pad_oe(pad_oe), .pad_pu(pad_pu), .chg_clr(chg_clr), .chg_flag(chg_flag),
      .ext_clr(ext_clr), .ext_flag(ext_flag)
   );

   // scoreboard: sel 0 rdata, 1 pad_out, 2 pad_oe, 3 pad_pu, 4 chg_flag, 5 ext_flag
   typedef struct {
      string      req;
      int         sel;
      logic [7:0] exp;
   } item_t;
   item_t sbq[$];

   function automatic logic [7:0] observe(int sel);
      case (sel)
         0: return bus_rdata;
         1: return pad_out;
         2: return pad_oe;
         3: return pad_pu;
         4: return {7'd0, chg_flag};
         default: return {7'd0, ext_flag};
      endcase
   endfunction

   always @(negedge clk) begin
      while (sbq.size() > 0) begin
         item_t it;
         logic [7:0] act;
         it  = sbq.pop_front();
         act = observe(it.sel);
         checks++;
         if (act !== it.exp) begin
            errors++;
            $display("FAIL %s sel=%0d actual=%02h expected=%02h", it.req, it.sel, act, it.exp);
         end
      end
   end

   // driver tasks: each starts and ends just after a rising edge
   task automatic step(int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic wr(logic [8:0] a, logic [7:0] d);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      step(1);
      bus_wr = 1'b0;
   endtask

   task automatic rd(logic [8:0] a, logic [7:0] e, string req);
      bus_addr = a; bus_rd = 1'b1;
      sbq.push_back('{req, 0, e});
      step(1);
      bus_rd = 1'b0;
   endtask

   task automatic expect_out(int sel, logic [7:0] e, string req);
      sbq.push_back('{req, sel, e});
      step(1);
   endtask

   task automatic pulse_chg_clr();
      chg_clr = 1'b1; step(1); chg_clr = 1'b0;
   endtask

   task automatic pulse_ext_clr();
      ext_clr = 1'b1; step(1); ext_clr = 1'b0;
   endtask

   initial begin
      step(3);
      rst_n = 1'b1;
      step(1);
      // reset state
      expect_out(2, 8'h00, "R2");
      expect_out(3, 8'h00, "R4");
      rd(9'h086, 8'hFF, "R2");
      rd(9'h081, 8'hFF, "R2");
      rd(9'h186, 8'hFF, "R10");
      expect_out(4, 8'h00, "R6");
      expect_out(5, 8'h00, "R9");
      rd(9'h007, 8'h00, "R10");

      // outputs
      wr(9'h006, 8'hA5);
      wr(9'h086, 8'h00);
      expect_out(1, 8'hA5, "R1");
      expect_out(2, 8'hFF, "R1");
      rd(9'h106, 8'h00, "R3");

      // synchronizer latency, read returns pins; upper bits are outputs so no flag
      pad_in = 8'h3C;
      rd(9'h006, 8'h00, "R3");
      rd(9'h006, 8'h00, "R3");
      rd(9'h006, 8'h3C, "R3");
      expect_out(4, 8'h00, "R5");

      // pull-ups
      wr(9'h086, 8'hF0);
      wr(9'h081, 8'h7F);
      expect_out(3, 8'hF0, "R4");
      wr(9'h181, 8'hFF);
      expect_out(3, 8'h00, "R4");
      wr(9'h081, 8'h7F);
      expect_out(4, 8'h00, "R5");

      // change against last-read snapshot
      pad_in = 8'h5C;
      step(3);
      expect_out(4, 8'h01, "R5");
      pulse_chg_clr();
      expect_out(4, 8'h01, "R6");
      rd(9'h006, 8'h5C, "R5");
      expect_out(4, 8'h01, "R6");
      pulse_chg_clr();
      expect_out(4, 8'h00, "R6");

      // lower nibble and bit 0 edges
      wr(9'h086, 8'hFF);
      expect_out(3, 8'hFF, "R4");
      pad_in = 8'h5D;
      step(3);
      expect_out(5, 8'h01, "R8");
      expect_out(4, 8'h00, "R7");
      expect_out(5, 8'h01, "R9");
      pulse_ext_clr();
      expect_out(5, 8'h00, "R9");
      pad_in = 8'h5E;
      step(3);
      expect_out(5, 8'h00, "R8");
      expect_out(4, 8'h00, "R7");
      wr(9'h081, 8'h3F);
      pad_in = 8'h5F;
      step(3);
      expect_out(5, 8'h00, "R8");
      pad_in = 8'h5E;
      step(3);
      expect_out(5, 8'h01, "R8");
      pulse_ext_clr();

      // decode
      wr(9'h007, 8'h00);
      rd(9'h086, 8'hFF, "R10");
      wr(9'h186, 8'h0F);
      rd(9'h086, 8'h0F, "R10");
      expect_out(2, 8'hF0, "R1");
      rd(9'h181, 8'h3F, "R2");

      // reset keeps output latch
      pad_in = 8'h00;
      step(3);
      rst_n = 1'b0;
      step(2);
      rst_n = 1'b1;
      step(1);
      rd(9'h086, 8'hFF, "R2");
      rd(9'h081, 8'hFF, "R2");
      expect_out(3, 8'h00, "R4");
      expect_out(4, 8'h00, "R6");
      expect_out(5, 8'h00, "R9");
      wr(9'h086, 8'h00);
      expect_out(1, 8'hA5, "R11");

      step(2);
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule